// File: doc/BRIEF.md
# Return-Address Stack Controller

This block holds the return addresses of a small processor core. A call pushes the current program-counter value and a return pops it. Software can also issue explicit push and pop requests. The entries live in a dedicated storage array, addressed by a 5-bit stack pointer. Pointer value 0 means the stack is empty, so entries 1 to 31 are usable. The entry the pointer addresses is the top of stack. The core sees it on `tos_o`.

Software has a byte-wide register port with four views. One is a status/pointer byte. The other three are slices of the top-of-stack entry (upper, high and low). Through these, software can move the pointer, replace a stored return address with its own data, and clear two sticky flags. One flag records that the stack filled or overflowed. The other records a pop from an empty stack. A configuration input decides whether these events also send a one-cycle reset request to the chip's reset controller.

All state is registered. Effects of a push, pop or register write show on the outputs one clock edge later. `reg_rdata_o` is a combinational view of the current state.

Top module: `ras_ctrl`

## Requirements
- R1: After `rst_ni` is released, the pointer is 0, both flags are 0, `rst_req_o` is 0, and every register view and `tos_o` read 0.
- R2: A push with pointer below 31 increments the pointer and stores `pc_i` in the newly addressed entry, which appears on `tos_o` after the edge.
- R3: A pop with a nonzero pointer decrements it, and the entry pushed before becomes `tos_o`.
- R4: A pop at pointer 0 leaves the pointer at 0, sets the underflow flag, and `tos_o` reads 0.
- R5: A push that brings the pointer to 31 sets the full flag. A push at pointer 31 sets the full flag, keeps the pointer at 31 and leaves entry 31 unchanged.
- R6: When push and pop are asserted in the same cycle, only the push takes effect.
- R7: `reg_sel_i` encoding: 0 selects the status byte, 1 the upper slice, 2 the high slice and 3 the low slice. The status byte has the full flag in bit 7, the underflow flag in bit 6, 0 in bit 5 and the pointer in bits 4:0. The upper slice carries entry bits 20:16 in bits 4:0 and reads 0 in bits 7:5. The high slice carries bits 15:8 and the low slice bits 7:0.
- R8: A status write loads bits 4:0 into the pointer. A 0 in bit 7 or bit 6 clears the matching flag. A 1 leaves that flag unchanged and never sets it.
- R9: A slice write replaces only the selected bits of the entry at the current pointer. At pointer 0 it has no effect.
- R10: A register write in a cycle with push or pop asserted is ignored.
- R11: With `rst_en_i` high, `rst_req_o` is high for the one cycle after each full or underflow event. With `rst_en_i` low it stays 0.
- R12: A set flag stays set through later pushes and pops until a status write clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low power-on reset |
| push_i | input | 1 | Push `pc_i` onto the stack |
| pop_i | input | 1 | Pop the top entry |
| pc_i | input | 21 | Program-counter value to push |
| rst_en_i | input | 1 | Configuration: full/underflow also requests device reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_sel_i | input | 2 | Register view select (0 status, 1 upper, 2 high, 3 low) |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Selected register view |
| tos_o | output | 21 | Current top-of-stack entry (0 when empty) |
| rst_req_o | output | 1 | One-cycle device-reset request |

## Verification
A pointer that is off by one shows up at the next edge: `tos_o` returns an address other than the one the model expects, and the status byte reports the wrong pointer. A wrong push address or a misdirected slice mask corrupts an entry silently. That damage becomes visible only when the pointer comes back to the entry, so the bench reads slices and pops back through the entries it has written. Flag faults show in status bits 7:6 and in `rst_req_o` in the cycle after the event. A stuck request or a lost clear persists until the bench reads the status byte again.

// File: rtl/ras_pkg.sv
package ras_pkg;
  typedef enum logic [1:0] {
    SEL_STAT  = 2'd0,
    SEL_UPPER = 2'd1,
    SEL_HIGH  = 2'd2,
    SEL_LOW   = 2'd3
  } reg_sel_e;

  localparam int unsigned STAT_FULL_BIT = 7;
  localparam int unsigned STAT_UNF_BIT  = 6;
  localparam int unsigned SLICE_W       = 8;
endpackage

// File: rtl/ras_ptr_ctrl.sv
module ras_ptr_ctrl #(
  parameter int unsigned PTR_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic             pop_i,
  input  logic             stat_wr_i,
  input  logic             keep_full_i,
  input  logic             keep_unf_i,
  input  logic [PTR_W-1:0] ptr_wdata_i,
  input  logic             rst_en_i,
  output logic [PTR_W-1:0] ptr_o,
  output logic             full_o,
  output logic             unf_o,
  output logic             rst_req_o,
  output logic             push_ok_o
);
  localparam logic [PTR_W-1:0] PTR_MAX  = '1;
  localparam logic [PTR_W-1:0] PTR_NEAR = PTR_MAX - 1'b1;

  logic [PTR_W-1:0] ptr_q, ptr_d;
  logic full_q, full_d, unf_q, unf_d, req_q;
  logic op, pop_only, ovf_evt, unf_evt, wr_ok;

  always_comb begin
    op        = push_i | pop_i;
    pop_only  = pop_i & ~push_i;
    push_ok_o = push_i & (ptr_q != PTR_MAX);
    ovf_evt   = push_i & (ptr_q >= PTR_NEAR);   // reaching or past the last entry
    unf_evt   = pop_only & (ptr_q == '0);
    wr_ok     = stat_wr_i & ~op;

    ptr_d = ptr_q;
    if (push_ok_o)                     ptr_d = ptr_q + 1'b1;
    else if (pop_only && ptr_q != '0)  ptr_d = ptr_q - 1'b1;
    else if (wr_ok)                    ptr_d = ptr_wdata_i;

    full_d = (full_q & ~(wr_ok & ~keep_full_i)) | ovf_evt;
    unf_d  = (unf_q  & ~(wr_ok & ~keep_unf_i))  | unf_evt;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q  <= '0;
      full_q <= 1'b0;
      unf_q  <= 1'b0;
      req_q  <= 1'b0;
    end else begin
      ptr_q  <= ptr_d;
      full_q <= full_d;
      unf_q  <= unf_d;
      req_q  <= rst_en_i & (ovf_evt | unf_evt);
    end
  end

  assign ptr_o     = ptr_q;
  assign full_o    = full_q;
  assign unf_o     = unf_q;
  assign rst_req_o = req_q;
endmodule

// File: rtl/ras_store.sv
module ras_store #(
  parameter int unsigned PC_W  = 21,
  parameter int unsigned PTR_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [PTR_W-1:0] wr_addr_i,
  input  logic [PC_W-1:0]  wr_data_i,
  input  logic [PC_W-1:0]  wr_mask_i,
  input  logic [PTR_W-1:0] rd_addr_i,
  output logic [PC_W-1:0]  rd_data_o
);
  localparam int unsigned SLOTS = 2 ** PTR_W;  // slot 0 is the empty marker, held at 0

  logic [PC_W-1:0] mem_q [SLOTS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < SLOTS; i++) mem_q[i] <= '0;
    end else if (wr_en_i && wr_addr_i != '0) begin
      mem_q[wr_addr_i] <= (mem_q[wr_addr_i] & ~wr_mask_i) | (wr_data_i & wr_mask_i);
    end
  end

  assign rd_data_o = mem_q[rd_addr_i];
endmodule

// File: rtl/ras_ctrl.sv
module ras_ctrl
  import ras_pkg::*;
#(
  parameter int unsigned PC_W  = 21,
  parameter int unsigned PTR_W = 5
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            push_i,
  input  logic            pop_i,
  input  logic [PC_W-1:0] pc_i,
  input  logic            rst_en_i,
  input  logic            reg_wr_i,
  input  logic [1:0]      reg_sel_i,
  input  logic [7:0]      reg_wdata_i,
  output logic [7:0]      reg_rdata_o,
  output logic [PC_W-1:0] tos_o,
  output logic            rst_req_o
);
  localparam int unsigned PAD_W = STAT_UNF_BIT - PTR_W;

  logic [PTR_W-1:0] ptr_w, wr_addr;
  logic             full_w, unf_w, push_ok, stat_wr, slice_wr, wr_en;
  logic [PC_W-1:0]  wr_data, wr_mask, tos_w;
  logic [1:0]       slice_idx;
  reg_sel_e         sel;

  assign sel       = reg_sel_e'(reg_sel_i);
  assign slice_idx = 2'(2'd3 - reg_sel_i);  // low=0, high=1, upper=2
  assign stat_wr   = reg_wr_i & (sel == SEL_STAT);
  assign slice_wr  = reg_wr_i & (sel != SEL_STAT) & ~push_i & ~pop_i;

  ras_ptr_ctrl #(.PTR_W(PTR_W)) u_ptr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .push_i     (push_i),
    .pop_i      (pop_i),
    .stat_wr_i  (stat_wr),
    .keep_full_i(reg_wdata_i[STAT_FULL_BIT]),
    .keep_unf_i (reg_wdata_i[STAT_UNF_BIT]),
    .ptr_wdata_i(reg_wdata_i[PTR_W-1:0]),
    .rst_en_i   (rst_en_i),
    .ptr_o      (ptr_w),
    .full_o     (full_w),
    .unf_o      (unf_w),
    .rst_req_o  (rst_req_o),
    .push_ok_o  (push_ok)
  );

  always_comb begin
    wr_en   = push_ok | slice_wr;
    wr_addr = ptr_w;
    wr_data = PC_W'({3{reg_wdata_i}});
    wr_mask = PC_W'(8'hFF) << (SLICE_W * slice_idx);
    if (push_ok) begin
      wr_addr = ptr_w + 1'b1;
      wr_data = pc_i;
      wr_mask = '1;
    end
  end

  ras_store #(.PC_W(PC_W), .PTR_W(PTR_W)) u_store (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en),
    .wr_addr_i(wr_addr),
    .wr_data_i(wr_data),
    .wr_mask_i(wr_mask),
    .rd_addr_i(ptr_w),
    .rd_data_o(tos_w)
  );

  always_comb begin
    if (sel == SEL_STAT) reg_rdata_o = {full_w, unf_w, {PAD_W{1'b0}}, ptr_w};
    else                 reg_rdata_o = 8'(tos_w >> (SLICE_W * slice_idx));
  end

  assign tos_o = tos_w;
endmodule

// File: rtl/ras_ctrl_chk.sv
module ras_ctrl_chk #(
  parameter int unsigned PTR_W = 5
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             push_i,
  input logic             pop_i,
  input logic             rst_en_i,
  input logic             reg_wr_i,
  input logic [1:0]       reg_sel_i,
  input logic             keep_full_i,
  input logic [7:0]       reg_rdata_o,
  input logic             rst_req_o,
  input logic [PTR_W-1:0] ptr,
  input logic             full,
  input logic             unf
);
  localparam logic [PTR_W-1:0] PTR_MAX = '1;

  // R2
  push_adv_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && ptr != PTR_MAX) |=> ptr == PTR_W'($past(ptr) + 1'b1));

  // R5
  push_sat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && ptr == PTR_MAX) |=> (ptr == PTR_MAX && full));

  // R3
  pop_dec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!push_i && pop_i && ptr != '0) |=> ptr == PTR_W'($past(ptr) - 1'b1));

  // R4
  pop_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!push_i && pop_i && ptr == '0) |=> (ptr == '0 && unf));

  // R12
  full_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full && !(reg_wr_i && reg_sel_i == 2'd0 && !push_i && !pop_i && !keep_full_i)) |=> full);

  // R11
  req_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |-> $past(rst_en_i));

  // R9
  empty_view_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ptr == '0 && reg_sel_i != 2'd0) |-> reg_rdata_o == 8'h00);
endmodule

bind ras_ctrl ras_ctrl_chk #(.PTR_W(PTR_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .push_i     (push_i),
  .pop_i      (pop_i),
  .rst_en_i   (rst_en_i),
  .reg_wr_i   (reg_wr_i),
  .reg_sel_i  (reg_sel_i),
  .keep_full_i(reg_wdata_i[7]),
  .reg_rdata_o(reg_rdata_o),
  .rst_req_o  (rst_req_o),
  .ptr        (ptr_w),
  .full       (full_w),
  .unf        (unf_w)
);

// File: tb/ras_ctrl_bench.sv
`timescale 1ns/100ps
module ras_ctrl_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        push_i = 1'b0, pop_i = 1'b0, rst_en_i = 1'b0, reg_wr_i = 1'b0;
  logic [20:0] pc_i = '0;
  logic [1:0]  reg_sel_i = '0;
  logic [7:0]  reg_wdata_i = '0;
  logic [7:0]  reg_rdata_o;
  logic [20:0] tos_o;
  logic        rst_req_o;

  int total = 0, bad = 0;
  bit done = 1'b0;
  int m_mem [32];
  int m_ptr = 0;
  bit m_full = 1'b0, m_unf = 1'b0;

  always #2.5 clk_i = ~clk_i;

  ras_ctrl u_ras_ctrl (.*);

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] s, output int v);
    reg_sel_i = s;
    #0.1;
    v = int'(reg_rdata_o);
  endtask

  task automatic chk_state(string req);
    int v;
    rd(2'd0, v);
    chk({req, " status"}, v, (int'(m_full) << 7) | (int'(m_unf) << 6) | m_ptr);
    chk({req, " tos"}, int'(tos_o), (m_ptr == 0) ? 0 : m_mem[m_ptr]);
  endtask

  // one clock cycle of stimulus, model update and request check
  task automatic cyc(string req, bit ps, bit pp, int pc, bit wr, logic [1:0] s, logic [7:0] wd);
    bit ev = 1'b0;
    push_i = ps; pop_i = pp; pc_i = 21'(pc);
    reg_wr_i = wr; reg_sel_i = s; reg_wdata_i = wd;
    @(posedge clk_i); #1;
    push_i = 1'b0; pop_i = 1'b0; reg_wr_i = 1'b0;
    if (ps) begin
      if (m_ptr < 31) begin
        m_ptr++; m_mem[m_ptr] = pc & 21'h1FFFFF;
        if (m_ptr == 31) begin m_full = 1'b1; ev = 1'b1; end
      end else begin m_full = 1'b1; ev = 1'b1; end
    end else if (pp) begin
      if (m_ptr == 0) begin m_unf = 1'b1; ev = 1'b1; end
      else m_ptr--;
    end else if (wr) begin
      if (s == 2'd0) begin
        m_ptr = int'(wd[4:0]);
        if (!wd[7]) m_full = 1'b0;
        if (!wd[6]) m_unf = 1'b0;
      end else if (m_ptr != 0) begin
        int sh = 8 * (3 - int'(s));
        m_mem[m_ptr] = ((m_mem[m_ptr] & ~(32'hFF << sh)) | (int'(wd) << sh)) & 21'h1FFFFF;
      end
    end
    chk({req, " rst_req"}, int'(rst_req_o), int'(rst_en_i & ev));
  endtask

  task automatic t_reset();
    int v;
    chk_state("R1");
    chk("R1 rst_req", int'(rst_req_o), 0);
    for (int s = 1; s < 4; s++) begin rd(2'(s), v); chk("R1 slice", v, 0); end
  endtask

  task automatic t_push_pop();
    cyc("R2", 1, 0, 21'h012345, 0, 0, 0); chk_state("R2");
    cyc("R2", 1, 0, 21'h1F0F0F, 0, 0, 0); chk_state("R2");
    cyc("R2", 1, 0, 21'h0000A5, 0, 0, 0); chk_state("R2");
    cyc("R3", 0, 1, 0, 0, 0, 0); chk_state("R3");
    cyc("R3", 0, 1, 0, 0, 0, 0); chk_state("R3");
    chk("R3 tos", int'(tos_o), 21'h012345);
  endtask

  task automatic t_priority();
    cyc("R6", 1, 1, 21'h0ABCDE, 0, 0, 0); chk_state("R6");
    chk("R6 tos", int'(tos_o), 21'h0ABCDE);
  endtask

  task automatic t_fill();
    rst_en_i = 1'b0;
    while (m_ptr < 30) cyc("R5", 1, 0, 21'h100 + m_ptr, 0, 0, 0);
    chk_state("R5 at30");
    cyc("R5", 1, 0, 21'h155555, 0, 0, 0); chk_state("R5 reach31");
    cyc("R5", 1, 0, 21'h0AAAAA, 0, 0, 0); chk_state("R5 overflow");
    chk("R5 keep top", int'(tos_o), 21'h155555);
    cyc("R12", 0, 1, 0, 0, 0, 0); chk_state("R12 pop keeps full");
    // with reset enabled
    cyc("R8", 0, 0, 0, 1, 2'd0, 8'h1E); chk_state("R8 clear+load30");
    rst_en_i = 1'b1;
    cyc("R11", 1, 0, 21'h0C0C0C, 0, 0, 0); chk_state("R11 full");
    cyc("R11", 0, 0, 0, 0, 0, 0);
    cyc("R11", 1, 0, 21'h000001, 0, 0, 0); chk_state("R11 ovf");
    rst_en_i = 1'b0;
  endtask

  task automatic t_status_write();
    cyc("R8", 0, 0, 0, 1, 2'd0, 8'hC5); chk_state("R8 keep flags");
    cyc("R8", 0, 0, 0, 1, 2'd0, 8'h45); chk_state("R8 clr full");
    cyc("R8", 0, 0, 0, 1, 2'd0, 8'h03); chk_state("R8 load3");
    cyc("R8", 0, 0, 0, 1, 2'd0, 8'hE0); chk_state("R8 no set, bit5");
  endtask

  task automatic t_underflow();
    rst_en_i = 1'b1;
    cyc("R4", 0, 1, 0, 0, 0, 0); chk_state("R4 underflow");
    cyc("R11", 0, 0, 0, 0, 0, 0); chk_state("R11 idle");
    rst_en_i = 1'b0;
    cyc("R4", 0, 1, 0, 0, 0, 0); chk_state("R4 again, no req");
    cyc("R12", 1, 0, 21'h000777, 0, 0, 0); chk_state("R12 unf sticky");
    cyc("R12", 0, 0, 0, 1, 2'd0, 8'h00); chk_state("R12 cleared");
  endtask

  task automatic t_slices();
    int v;
    cyc("R9", 1, 0, 21'h1ABCDE, 0, 0, 0);
    cyc("R9", 0, 0, 0, 1, 2'd3, 8'h11); chk_state("R9 low");
    cyc("R9", 0, 0, 0, 1, 2'd2, 8'h22); chk_state("R9 high");
    cyc("R9", 0, 0, 0, 1, 2'd1, 8'hFF); chk_state("R9 upper");
    chk("R9 value", int'(tos_o), 21'h1F2211);
    rd(2'd1, v); chk("R7 upper", v, 8'h1F);
    rd(2'd2, v); chk("R7 high", v, 8'h22);
    rd(2'd3, v); chk("R7 low", v, 8'h11);
    cyc("R9", 0, 0, 0, 1, 2'd0, 8'h00);
    cyc("R9", 0, 0, 0, 1, 2'd3, 8'h55); chk_state("R9 empty ignore");
    rd(2'd3, v); chk("R9 empty low", v, 0);
    cyc("R9", 1, 0, 21'h000042, 0, 0, 0); chk_state("R9 after empty");
  endtask

  task automatic t_busy_writes();
    cyc("R10", 1, 0, 21'h013579, 1, 2'd0, 8'h1F); chk_state("R10 stat+push");
    cyc("R10", 0, 1, 0, 1, 2'd3, 8'hEE); chk_state("R10 slice+pop");
    cyc("R10", 0, 0, 0, 1, 2'd0, 8'h02); chk_state("R10 revisit");
  endtask

  initial begin
    for (int i = 0; i < 32; i++) m_mem[i] = 0;
    repeat (2) @(posedge clk_i);
    #1 rst_ni = 1'b1;
    @(posedge clk_i); #1;
    t_reset();
    t_push_pop();
    t_priority();
    t_fill();
    t_status_write();
    t_underflow();
    t_slices();
    t_busy_writes();
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1'b1;
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule